// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds the receive side of a CAN controller's mailbox store. A protocol engine upstream presents one decoded frame per cycle: identifier, extended flag, remote flag, length code and eight data bytes. The bank writes each frame into the lowest-numbered mailbox that can take it. That mailbox stays full and keeps its contents until software re-arms it with a bitmask command.

Each mailbox has a mode word. The last mailbox can run in overwrite mode. In that mode it absorbs frames that no other mailbox can take, and flags each lost message.

Software reads four things through a single indexed read port: a mailbox's mode, identifier, status and data words. A ready bitmap and a masked interrupt line report which mailboxes hold unread frames. A saturating counter records frames that had nowhere to go.

Top module: `can_rxmb_bank`

## Requirements
- R1: A frame accepted on `frm_valid` is stored in the lowest-numbered mailbox whose mode is receive (1) or receive-with-overwrite (2) and that is empty. Bit i of `ready_map` (mailbox i) rises at the clock edge that samples the frame.
- R2: A mailbox in mode 0 (disabled) or mode 3 (transmit) never takes a frame. The mode word keeps the mode in bits 26:24 and a 4-bit priority in bits 19:16; every other bit reads 0. A mode write takes effect for frames from the next cycle onward.
- R3: A full mailbox keeps its ready bit and its contents until it is re-armed. Later frames go to other mailboxes.
- R4: A re-arm command empties every mailbox whose bit is set in `rearm_mask` and leaves the others alone. Mask 0x0FF empties mailboxes 0 to 7 together.
- R5: Status word layout:
  - bit 24: message lost
  - bit 23: full
  - bit 20: remote flag
  - bits 19:16: length code
  - all other bits: 0

  Re-arming clears bits 24 and 23 and keeps the remote flag and length code.
- R6: Identifier word layout:
  - bit 29: extended flag
  - extended frame: identifier in bits 28:0
  - standard frame: 11-bit identifier in bits 28:18, bits 17:0 zero
  - bits 31:30: always 0
- R7: The low data word holds bytes 0 to 3 and the high data word holds bytes 4 to 7, little-endian within each word. Byte k enters on `frm_data[8k+7:8k]`.
- R8: This rule applies when the last mailbox is in mode 2, is full, and no other mailbox is free. A new frame then replaces its contents and sets the lost flag. Filling an empty mailbox never sets the lost flag, and re-arming clears it. Mode 2 has no overwrite effect on any other mailbox.
- R9: A frame that finds no free mailbox, and cannot overwrite, is discarded without changing any mailbox. `ovf_count` then increments, saturating at its maximum value (255 by default).
- R10: `irq` is high exactly when some bit is set in both `ready_map` and `irq_mask`.
- R11: When a re-arm and a frame arrive in the same cycle, the frame may land in a mailbox that this re-arm frees.
- R12: After reset every mailbox is empty with its lost flag clear, and `ovf_count` is 0. Mailboxes 0 to N-2 are in mode 1 and the last mailbox is in mode 2, all with priority 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A decoded frame is present this cycle |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_ext | input | 1 | Extended-identifier frame |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data, byte k at bits 8k+7:8k |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_idx | input | 4 | Mailbox addressed by the mode write |
| cfg_word | input | 32 | Mode word (mode 26:24, priority 19:16) |
| rearm_we | input | 1 | Re-arm command strobe |
| rearm_mask | input | 12 | One bit per mailbox to re-arm |
| irq_mask | input | 12 | Interrupt enable per mailbox |
| rd_idx | input | 4 | Mailbox selected on the read port |
| rd_mode_word | output | 32 | Mode word of the selected mailbox |
| rd_id_word | output | 32 | Identifier word of the selected mailbox |
| rd_stat_word | output | 32 | Status word of the selected mailbox |
| rd_data_lo | output | 32 | Data bytes 0 to 3 |
| rd_data_hi | output | 32 | Data bytes 4 to 7 |
| ready_map | output | 12 | Full flag of each mailbox |
| irq | output | 1 | Masked ready interrupt |
| ovf_count | output | 8 | Saturating count of discarded frames |

## Verification
The bench targets four weak spots.

- **Fill order.** It frees a single low mailbox while higher ones are full and checks that the next frame goes into the hole. A fill pointer that only advances would skip the hole.
- **Overwrite.** It drives the last mailbox through overwrite, re-arm and a fresh fill. A design that mishandled the lost flag would leave it stuck, set it on a normal fill, or let the overwrite frame bump the drop counter.
- **Mode changes.** It switches the last mailbox out of overwrite mode and sends frames. A design that wrongly kept overwriting would corrupt its identifier, and the bench also drives the drop counter past saturation.
- **Same-cycle re-arm.** It issues a re-arm in the same cycle as a frame. A design that ordered the two wrongly would drop that frame instead of storing it.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;

    typedef enum logic [2:0] {
        MB_OFF   = 3'd0,
        MB_RX    = 3'd1,
        MB_RX_OW = 3'd2,
        MB_TX    = 3'd3
    } mb_mode_e;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        mb_mode_e            mode;
        logic [3:0]          prio;
        logic                full;
        logic                lost;
        logic                ext;
        logic                rtr;
        logic [DLC_W-1:0]    dlc;
        logic [ID_W-1:0]     id;
        logic [DATA_W-1:0]   data;
    } mb_t;

endpackage

// File: rtl/rxmb_lowest_free.sv
module rxmb_lowest_free #(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     free_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rxmb_word_fmt.sv
module rxmb_word_fmt #(
    parameter int ID_W  = 29,
    parameter int DLC_W = 4
) (
    input  logic [ID_W-1:0]  id,
    input  logic             ext,
    input  logic             rtr,
    input  logic [DLC_W-1:0] dlc,
    input  logic             full,
    input  logic             lost,
    output logic [31:0]      id_word,
    output logic [31:0]      stat_word
);
    localparam int STD_W = 11;
    localparam int STD_SHIFT = ID_W - STD_W;

    always_comb begin
        id_word = '0;
        if (ext) begin
            id_word[ID_W-1:0] = id;
            id_word[29]       = 1'b1;
        end else begin
            id_word[ID_W-1:STD_SHIFT] = id[STD_W-1:0];
        end
        stat_word = '0;
        stat_word[24]                = lost;
        stat_word[23]                = full;
        stat_word[20]                = rtr;
        stat_word[16 +: DLC_W]       = dlc;
    end
endmodule

// File: rtl/can_rxmb_bank.sv
module can_rxmb_bank
    import can_rxmb_pkg::*;
#(
    parameter int NUM_MB = 12,
    parameter int IDX_W  = 4,
    parameter int OVF_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frm_valid,
    input  logic [ID_W-1:0]       frm_id,
    input  logic                  frm_ext,
    input  logic                  frm_rtr,
    input  logic [DLC_W-1:0]      frm_dlc,
    input  logic [DATA_W-1:0]     frm_data,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [31:0]           cfg_word,
    input  logic                  rearm_we,
    input  logic [NUM_MB-1:0]     rearm_mask,
    input  logic [NUM_MB-1:0]     irq_mask,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [31:0]           rd_mode_word,
    output logic [31:0]           rd_id_word,
    output logic [31:0]           rd_stat_word,
    output logic [31:0]           rd_data_lo,
    output logic [31:0]           rd_data_hi,
    output logic [NUM_MB-1:0]     ready_map,
    output logic                  irq,
    output logic [OVF_W-1:0]      ovf_count
);
    localparam int LAST = NUM_MB - 1;
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    typedef struct packed {
        mb_t [NUM_MB-1:0] mbs;
        logic [OVF_W-1:0] ovf;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_MB-1:0] free_vec;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;

    // Free vector sees this cycle's re-arm, so a re-armed slot can take the frame.
    always_comb begin
        for (int i = 0; i < NUM_MB; i++) begin
            free_vec[i] = (state_q.mbs[i].mode inside {MB_RX, MB_RX_OW}) &&
                          (!state_q.mbs[i].full || (rearm_we && rearm_mask[i]));
        end
    end

    rxmb_lowest_free #(.N(NUM_MB), .IDX_W(IDX_W)) u_pick (
        .free_vec (free_vec),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_we && (int'(cfg_idx) < NUM_MB)) begin
            state_d.mbs[cfg_idx].mode = mb_mode_e'(cfg_word[26:24]);
            state_d.mbs[cfg_idx].prio = cfg_word[19:16];
        end
        if (rearm_we) begin
            for (int i = 0; i < NUM_MB; i++) begin
                if (rearm_mask[i]) begin
                    state_d.mbs[i].full = 1'b0;
                    state_d.mbs[i].lost = 1'b0;
                end
            end
        end
        if (frm_valid) begin
            if (pick_found) begin
                state_d.mbs[pick_idx].full = 1'b1;
                state_d.mbs[pick_idx].lost = 1'b0;
                state_d.mbs[pick_idx].ext  = frm_ext;
                state_d.mbs[pick_idx].rtr  = frm_rtr;
                state_d.mbs[pick_idx].dlc  = frm_dlc;
                state_d.mbs[pick_idx].id   = frm_id;
                state_d.mbs[pick_idx].data = frm_data;
            end else if (state_q.mbs[LAST].mode == MB_RX_OW) begin
                state_d.mbs[LAST].full = 1'b1;
                state_d.mbs[LAST].lost = 1'b1;
                state_d.mbs[LAST].ext  = frm_ext;
                state_d.mbs[LAST].rtr  = frm_rtr;
                state_d.mbs[LAST].dlc  = frm_dlc;
                state_d.mbs[LAST].id   = frm_id;
                state_d.mbs[LAST].data = frm_data;
            end else if (state_q.ovf != OVF_MAX) begin
                state_d.ovf = state_q.ovf + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MB; i++) begin
                state_q.mbs[i]      <= '0;
                state_q.mbs[i].mode <= (i == LAST) ? MB_RX_OW : MB_RX;
            end
            state_q.ovf <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Read port
    mb_t rd_mb;
    always_comb begin
        rd_mb = '0;
        if (int'(rd_idx) < NUM_MB) rd_mb = state_q.mbs[rd_idx];
    end

    rxmb_word_fmt #(.ID_W(ID_W), .DLC_W(DLC_W)) u_fmt (
        .id        (rd_mb.id),
        .ext       (rd_mb.ext),
        .rtr       (rd_mb.rtr),
        .dlc       (rd_mb.dlc),
        .full      (rd_mb.full),
        .lost      (rd_mb.lost),
        .id_word   (rd_id_word),
        .stat_word (rd_stat_word)
    );

    always_comb begin
        rd_mode_word        = '0;
        rd_mode_word[26:24] = rd_mb.mode;
        rd_mode_word[19:16] = rd_mb.prio;
        rd_data_lo          = rd_mb.data[31:0];
        rd_data_hi          = rd_mb.data[63:32];
        for (int i = 0; i < NUM_MB; i++) ready_map[i] = state_q.mbs[i].full;
    end

    assign irq       = |(ready_map & irq_mask);
    assign ovf_count = state_q.ovf;

endmodule

// File: rtl/can_rxmb_bank_chk.sv
module can_rxmb_bank_chk #(
    parameter int NUM_MB = 12,
    parameter int OVF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic              rearm_we,
    input logic [NUM_MB-1:0] rearm_mask,
    input logic [NUM_MB-1:0] irq_mask,
    input logic [NUM_MB-1:0] ready_map,
    input logic              irq,
    input logic [OVF_W-1:0]  ovf_count
);
    AST_ONE_FILL_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ready_map & ~$past(ready_map)) <= 1); // R1

    AST_FILL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_map & ~$past(ready_map)) != '0) |-> $past(frm_valid)); // R1

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ready_map) & ~($past(rearm_we) ? $past(rearm_mask) : '0)) & ~ready_map) == '0); // R3

    AST_REARM_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rearm_we) && !$past(frm_valid)) |-> ((ready_map & $past(rearm_mask)) == '0)); // R4

    AST_OVF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count != $past(ovf_count)) |-> $past(frm_valid)); // R9

    AST_OVF_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_count >= $past(ovf_count)); // R9

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((ready_map & irq_mask) != '0)); // R10
endmodule

bind can_rxmb_bank can_rxmb_bank_chk #(.NUM_MB(NUM_MB), .OVF_W(OVF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .rearm_we   (rearm_we),
    .rearm_mask (rearm_mask),
    .irq_mask   (irq_mask),
    .ready_map  (ready_map),
    .irq        (irq),
    .ovf_count  (ovf_count)
);

// File: tb/tb_can_rxmb_bank.sv
`timescale 1ns/1ps
module tb_can_rxmb_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_valid;
    logic [28:0] frm_id;
    logic        frm_ext, frm_rtr;
    logic [3:0]  frm_dlc;
    logic [63:0] frm_data;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [31:0] cfg_word;
    logic        rearm_we;
    logic [11:0] rearm_mask, irq_mask;
    logic [3:0]  rd_idx;
    logic [31:0] rd_mode_word, rd_id_word, rd_stat_word, rd_data_lo, rd_data_hi;
    logic [11:0] ready_map;
    logic        irq;
    logic [7:0]  ovf_count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    can_rxmb_bank dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
        .rearm_we(rearm_we), .rearm_mask(rearm_mask), .irq_mask(irq_mask),
        .rd_idx(rd_idx), .rd_mode_word(rd_mode_word), .rd_id_word(rd_id_word),
        .rd_stat_word(rd_stat_word), .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi),
        .ready_map(ready_map), .irq(irq), .ovf_count(ovf_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic sel(input int idx);
        rd_idx = 4'(idx);
        #1;
    endtask

    // Drive one frame for one cycle, optionally together with a re-arm.
    task automatic send(input logic [28:0] id, input logic ext, input logic rtr,
                        input logic [3:0] dlc, input logic [63:0] data,
                        input logic do_rearm, input logic [11:0] mask);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ext = ext; frm_rtr = rtr;
        frm_dlc = dlc; frm_data = data;
        rearm_we = do_rearm; rearm_mask = mask;
        @(negedge clk);
        frm_valid = 1'b0; rearm_we = 1'b0; rearm_mask = '0;
    endtask

    task automatic send_std(input int id);
        send(29'(id), 1'b0, 1'b0, 4'd1, 64'h0, 1'b0, '0);
    endtask

    task automatic rearm(input logic [11:0] mask);
        @(negedge clk);
        rearm_we = 1'b1; rearm_mask = mask;
        @(negedge clk);
        rearm_we = 1'b0; rearm_mask = '0;
    endtask

    task automatic cfg(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 ready after reset", 64'(ready_map), 64'h0);
        chk("R12 ovf after reset", 64'(ovf_count), 64'h0);
        chk("R12 irq after reset", 64'(irq), 64'h0);
        sel(0);  chk("R12 mode mb0", 64'(rd_mode_word), 64'h0100_0000);
        sel(11); chk("R12 mode mb11", 64'(rd_mode_word), 64'h0200_0000);
        chk("R12 stat mb11", 64'(rd_stat_word), 64'h0);
    endtask

    task automatic t_fields;
        send(29'h123, 1'b0, 1'b0, 4'd8, 64'h8877_6655_4433_2211, 1'b0, '0);
        chk("R1 first frame to mb0", 64'(ready_map), 64'h001);
        sel(0);
        chk("R6 std id word", 64'(rd_id_word), 64'h048C_0000);
        chk("R5 status std", 64'(rd_stat_word), 64'h0088_0000);
        chk("R7 data lo", 64'(rd_data_lo), 64'h4433_2211);
        chk("R7 data hi", 64'(rd_data_hi), 64'h8877_6655);
        send(29'h1ABC_DEF0, 1'b1, 1'b1, 4'd3, 64'h0, 1'b0, '0);
        chk("R1 second frame to mb1", 64'(ready_map), 64'h003);
        sel(1);
        chk("R6 ext id word", 64'(rd_id_word), 64'h3ABC_DEF0);
        chk("R5 status rtr", 64'(rd_stat_word), 64'h0093_0000);
    endtask

    task automatic t_hole;
        rearm(12'h001);
        chk("R4 single rearm", 64'(ready_map), 64'h002);
        send_std(12'h0AA);
        chk("R1 frame fills hole mb0", 64'(ready_map), 64'h003);
        sel(0); chk("R1 hole id", 64'(rd_id_word), 64'h02A8_0000);
        sel(1); chk("R3 mb1 kept", 64'(rd_id_word), 64'h3ABC_DEF0);
    endtask

    task automatic t_modes;
        cfg(2, 32'h0005_0000);
        sel(2); chk("R2 mode word readback", 64'(rd_mode_word), 64'h0005_0000);
        send_std(12'h011);
        chk("R2 disabled mb2 skipped", 64'(ready_map), 64'h00B);
        cfg(2, 32'h0300_0000);
        send_std(12'h012);
        chk("R2 transmit mb2 skipped", 64'(ready_map), 64'h01B);
        cfg(2, 32'h0100_0000);
    endtask

    task automatic t_rearm_low;
        rearm(12'hFFF);
        chk("R4 rearm all", 64'(ready_map), 64'h000);
        for (int i = 0; i < 8; i++) send_std(i);
        chk("R1 eight frames", 64'(ready_map), 64'h0FF);
        rearm(12'h0FF);
        chk("R4 mask 0xFF", 64'(ready_map), 64'h000);
    endtask

    task automatic t_overwrite;
        for (int i = 0; i < 12; i++) send_std(i);
        chk("R1 all full", 64'(ready_map), 64'hFFF);
        sel(11); chk("R8 no lost on normal fill", 64'(rd_stat_word), 64'h0081_0000);
        send(29'h7FF, 1'b0, 1'b0, 4'd2, 64'h0, 1'b0, '0);
        sel(11);
        chk("R8 overwrite id", 64'(rd_id_word), 64'h1FFC_0000);
        chk("R8 lost set", 64'(rd_stat_word), 64'h0182_0000);
        chk("R8 no drop count", 64'(ovf_count), 64'h0);
        sel(10); chk("R3 mb10 untouched", 64'(rd_id_word), 64'h0028_0000);
        rearm(12'h800);
        chk("R4 rearm mb11", 64'(ready_map), 64'h7FF);
        sel(11); chk("R5 rearm clears full lost", 64'(rd_stat_word), 64'h0002_0000);
        send_std(12'h010);
        sel(11); chk("R8 fresh fill no lost", 64'(rd_stat_word), 64'h0081_0000);
    endtask

    task automatic t_drop;
        cfg(11, 32'h0100_0000);
        send_std(12'h055);
        chk("R9 drop counted", 64'(ovf_count), 64'h1);
        sel(11); chk("R9 mb11 unchanged", 64'(rd_id_word), 64'h0040_0000);
        for (int i = 0; i < 300; i++) send_std(12'h055);
        chk("R9 saturation", 64'(ovf_count), 64'hFF);
        cfg(11, 32'h0200_0000);
    endtask

    task automatic t_irq;
        rearm(12'hFFF);
        irq_mask = 12'h004;
        send_std(1); #1 chk("R10 irq masked mb0", 64'(irq), 64'h0);
        send_std(2); #1 chk("R10 irq masked mb1", 64'(irq), 64'h0);
        send_std(3); #1 chk("R10 irq on mb2", 64'(irq), 64'h1);
        irq_mask = 12'h000; #1 chk("R10 irq mask off", 64'(irq), 64'h0);
    endtask

    task automatic t_same_cycle;
        send(29'h066, 1'b0, 1'b0, 4'd1, 64'h0, 1'b1, 12'h001);
        chk("R11 ready after rearm+frame", 64'(ready_map), 64'h007);
        sel(0); chk("R11 frame in rearmed mb0", 64'(rd_id_word), 64'h0198_0000);
    endtask

    initial begin
        #(20.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frm_valid = 1'b0; frm_id = '0; frm_ext = 1'b0; frm_rtr = 1'b0;
        frm_dlc = '0; frm_data = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_word = '0;
        rearm_we = 1'b0; rearm_mask = '0; irq_mask = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fields;
        t_hole;
        t_modes;
        t_rearm_low;
        t_overwrite;
        t_drop;
        t_irq;
        t_same_cycle;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule